// File: doc/BRIEF.md
# GPIO Pad Bank with Interrupts

A memory-mapped bank of general-purpose pads. Each pad owns a 16-byte register window. The window holds a configuration word and a value word. The configuration word selects the interrupt trigger, a pin-function field, a direct-interrupt flag and an open-drain output style. The value word holds the output level and two active-low enables, one for the input path and one for the output path. Every pad input passes through a synchronizer. The synchronized signal drives a per-pad trigger detector, which sets a sticky pending bit in a shared status register. Software clears a pending bit by writing 1 to it. The OR of all pending bits forms one interrupt line.

The register bus is a plain single-cycle port. A write is taken on the clock edge while `bus_wr_en` is high. Read data is a combinational function of `bus_addr` and the current state.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset every configuration word reads 0x00000000, every value word reads 0x00000006 (both enables inactive, level 0), the status word reads 0, and `irq` and all `pad_oe` bits are 0.
- R2: Pad p has its configuration word at byte address p*16 and its value word at p*16+8. The status word is at 0x800. Any other address reads 0, and a write to it changes nothing. Only configuration bits 31 (open-drain), 27 (direct interrupt), 26..24 (trigger) and 2..0 (function) are stored; every other bit reads 0.
- R3: In the value word, bit 0 is the level, bit 1 is the output enable (0 = on) and bit 2 is the input enable (0 = on). While bit 2 is 0, bit 0 reads the pad input after a two-flop synchronizer: a pad change first shows after the second clock edge. While bit 2 is 1, bit 0 reads the stored level.
- R4: With open-drain off and bit 1 = 0, `pad_oe` is 1 and `pad_out` equals the level. With bit 1 = 1, `pad_oe` is 0.
- R5: With configuration bit 31 = 1 and bit 1 of the value word = 0, a level of 0 gives `pad_oe` = 1 and `pad_out` = 0. A level of 1 releases the pad (`pad_oe` = 0).
- R6: With bit 24 clear, bit 25 sets the pending bit on a synchronized 0-to-1 transition. Bit 26 sets it on a 1-to-0 transition. With both bits set, either transition sets it.
- R7: With bit 24 set, bit 25 sets the pending bit while the synchronized pad is high, and bit 26 sets it while the pad is low.
- R8: A pad whose bits 26..24 are all 0 never sets its pending bit.
- R9: Writing a 1 to status bit p clears it, and writing 0 leaves it unchanged. After a clear, a bit reads 0 while its trigger condition is inactive. An edge detected in the same cycle as the clear is kept.
- R10: For a level-triggered pad whose condition still holds, a cleared bit reads 0 in the cycle after the write and is set again one cycle later.
- R11: `irq` is 1 exactly when at least one status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NUM_PADS | Asynchronous pad inputs |
| pad_out | output | NUM_PADS | Pad output levels |
| pad_oe | output | NUM_PADS | Pad output drivers enabled |
| irq | output | 1 | Combined interrupt, OR of pending bits |

## Verification
The bench builds the bank with NUM_PADS = 8 and keeps the default two-stage synchronizer. With eight pads it can sweep all eight trigger codes on every pad through a low, high, low sequence, and it checks the whole status vector each time, so stray bits on neighbouring pads are caught. The small size also leaves room for a drive sweep over every pad and level, for cycle-exact probes of synchronizer latency, and for the clear-versus-edge and clear-versus-level collisions.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int WORD_W = 32;

  // Configuration word bit positions (decoded by the pad slice)
  localparam int CFG_OD_BIT   = 31;
  localparam int CFG_DIRQ_BIT = 27;
  localparam int CFG_FALL_BIT = 26;
  localparam int CFG_RISE_BIT = 25;
  localparam int CFG_LVL_BIT  = 24;

  typedef struct packed {
    logic       open_drain;
    logic       direct_irq;
    logic       trig_fall;
    logic       trig_rise;
    logic       trig_level;
    logic [2:0] func_sel;
  } pad_cfg_t;

  typedef struct packed {
    logic in_off;   // input enable, active low
    logic out_off;  // output enable, active low
    logic level;
  } pad_val_t;

  localparam pad_val_t VAL_RESET = '{in_off: 1'b1, out_off: 1'b1, level: 1'b0};

  function automatic pad_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
    pad_cfg_t c;
    c.open_drain = w[CFG_OD_BIT];
    c.direct_irq = w[CFG_DIRQ_BIT];
    c.trig_fall  = w[CFG_FALL_BIT];
    c.trig_rise  = w[CFG_RISE_BIT];
    c.trig_level = w[CFG_LVL_BIT];
    c.func_sel   = w[2:0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(input pad_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CFG_OD_BIT]   = c.open_drain;
    w[CFG_DIRQ_BIT] = c.direct_irq;
    w[CFG_FALL_BIT] = c.trig_fall;
    w[CFG_RISE_BIT] = c.trig_rise;
    w[CFG_LVL_BIT]  = c.trig_level;
    w[2:0]          = c.func_sel;
    return w;
  endfunction

  // Trigger evaluation: level mode reuses rise/fall as high/low detect
  function automatic logic trigger_fires(input pad_cfg_t c, input logic cur, input logic prv);
    logic up, down;
    up   = cur & ~prv;
    down = ~cur & prv;
    if (c.trig_level)
      return (c.trig_rise & cur) | (c.trig_fall & ~cur);
    else
      return (c.trig_rise & up) | (c.trig_fall & down);
  endfunction

  // Returns {enable, level} for the pad driver
  function automatic logic [1:0] drive_of(input pad_val_t v, input logic od);
    logic en;
    en = ~v.out_off;
    if (od)
      return {en & ~v.level, 1'b0};
    else
      return {en, v.level};
  endfunction

endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic cur,
  output logic prv
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= din;
  end

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[k] <= 1'b0;
      else        chain_q[k] <= chain_q[k-1];
    end
  end

  assign cur = chain_q[STAGES-1];
  assign prv = chain_q[STAGES];
endmodule

// File: rtl/gpio_pad_slice.sv
module gpio_pad_slice
  import gpio_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              val_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pin,
  output logic [WORD_W-1:0] cfg_word,
  output logic [WORD_W-1:0] val_word,
  output logic              drv_out,
  output logic              drv_oe,
  output logic              hit,
  output logic              lvl_mode,
  output logic              no_trig,
  output logic              od_sel
);
  pad_cfg_t cfg_q;
  pad_val_t val_q;
  logic     pin_cur, pin_prv;
  logic [1:0] drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_from_word(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= VAL_RESET;
    else if (val_we) val_q <= pad_val_t'(wdata[2:0]);
  end

  gpio_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin),
    .cur  (pin_cur),
    .prv  (pin_prv)
  );

  assign hit      = trigger_fires(cfg_q, pin_cur, pin_prv);
  assign lvl_mode = cfg_q.trig_level;
  assign no_trig  = ~(cfg_q.trig_level | cfg_q.trig_rise | cfg_q.trig_fall);
  assign od_sel   = cfg_q.open_drain;

  assign drv     = drive_of(val_q, cfg_q.open_drain);
  assign drv_oe  = drv[1];
  assign drv_out = drv[0];

  assign cfg_word = cfg_to_word(cfg_q);
  assign val_word = {{(WORD_W-3){1'b0}}, val_q.in_off, val_q.out_off,
                     val_q.in_off ? val_q.level : pin_cur};
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NUM_PADS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] clr,
  input  logic [NUM_PADS-1:0] hit,
  input  logic [NUM_PADS-1:0] lvl_mode,
  output logic [NUM_PADS-1:0] pending,
  output logic                irq
);
  // A level hit colliding with a clear is held off one cycle; edges always win.
  logic [NUM_PADS-1:0] set_now;
  assign set_now = hit & ~(clr & lvl_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending & ~clr) | set_now;
  end

  assign irq = |pending;
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PADS    = 32,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic                irq
);
  localparam int                IDX_W     = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] PAD_SPAN  = ADDR_W'(NUM_PADS * 16);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(12'h800);
  localparam logic [3:0]        OFS_CFG   = 4'h0;
  localparam logic [3:0]        OFS_VAL   = 4'h8;

  logic [IDX_W-1:0]    win_idx;
  logic [3:0]          win_ofs;
  logic                in_pads;
  logic                stat_sel;

  logic [WORD_W-1:0]   cfg_words [NUM_PADS];
  logic [WORD_W-1:0]   val_words [NUM_PADS];
  logic [NUM_PADS-1:0] pad_hit, pad_lvl, pad_notrig, pad_od;
  logic [NUM_PADS-1:0] stat_clr, status_q;

  assign win_idx  = bus_addr[ADDR_W-1:4];
  assign win_ofs  = bus_addr[3:0];
  assign in_pads  = bus_addr < PAD_SPAN;
  assign stat_sel = bus_addr == STAT_ADDR;
  assign stat_clr = (bus_wr_en && stat_sel) ? bus_wdata[NUM_PADS-1:0] : '0;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic win_hit;
    assign win_hit = in_pads && (win_idx == IDX_W'(p));

    gpio_pad_slice #(.SYNC_STAGES(SYNC_STAGES)) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (bus_wr_en && win_hit && win_ofs == OFS_CFG),
      .val_we  (bus_wr_en && win_hit && win_ofs == OFS_VAL),
      .wdata   (bus_wdata),
      .pin     (pad_in[p]),
      .cfg_word(cfg_words[p]),
      .val_word(val_words[p]),
      .drv_out (pad_out[p]),
      .drv_oe  (pad_oe[p]),
      .hit     (pad_hit[p]),
      .lvl_mode(pad_lvl[p]),
      .no_trig (pad_notrig[p]),
      .od_sel  (pad_od[p])
    );
  end

  gpio_irq_status #(.NUM_PADS(NUM_PADS)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (stat_clr),
    .hit     (pad_hit),
    .lvl_mode(pad_lvl),
    .pending (status_q),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (stat_sel) begin
      bus_rdata = WORD_W'(status_q);
    end else if (in_pads) begin
      for (int p = 0; p < NUM_PADS; p++) begin
        if (win_idx == IDX_W'(p)) begin
          if (win_ofs == OFS_CFG) bus_rdata = cfg_words[p];
          if (win_ofs == OFS_VAL) bus_rdata = val_words[p];
        end
      end
    end
  end
endmodule

// File: rtl/gpio_pad_bank_chk.sv
module gpio_pad_bank_chk #(
  parameter int NUM_PADS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq,
  input logic [NUM_PADS-1:0] status_q,
  input logic [NUM_PADS-1:0] pad_hit,
  input logic [NUM_PADS-1:0] pad_lvl,
  input logic [NUM_PADS-1:0] pad_notrig,
  input logic [NUM_PADS-1:0] stat_clr,
  input logic [NUM_PADS-1:0] pad_od,
  input logic [NUM_PADS-1:0] pad_out,
  input logic [NUM_PADS-1:0] pad_oe
);
  assert_untriggered_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & $past(pad_notrig)) == '0));

  assert_clear_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_clr & ~pad_hit)) |=> ((status_q & $past(stat_clr & ~pad_hit)) == '0));

  assert_edge_not_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pad_hit & ~pad_lvl)) |=>
      ((status_q & $past(pad_hit & ~pad_lvl)) == $past(pad_hit & ~pad_lvl)));

  assert_level_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_clr & pad_hit & pad_lvl)) |=>
      ((status_q & $past(stat_clr & pad_hit & pad_lvl)) == '0));

  assert_irq_rise_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(pad_hit) != '0));

  assert_irq_fall_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(stat_clr) != '0));

  assert_od_never_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_od & pad_out) == '0);
endmodule

bind gpio_pad_bank gpio_pad_bank_chk #(.NUM_PADS(NUM_PADS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .status_q  (status_q),
  .pad_hit   (pad_hit),
  .pad_lvl   (pad_lvl),
  .pad_notrig(pad_notrig),
  .stat_clr  (stat_clr),
  .pad_od    (pad_od),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/gpio_pad_bank_test.sv
`timescale 1ns/1ps
module gpio_pad_bank_test;
  localparam int N  = 8;
  localparam int AW = 12;
  localparam logic [AW-1:0] STAT = 12'h800;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe;
  logic          irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_pad_bank #(.NUM_PADS(N), .ADDR_W(AW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [AW-1:0] cfg_at(int p); return AW'(p * 16);     endfunction
  function automatic logic [AW-1:0] val_at(int p); return AW'(p * 16 + 8); endfunction

  // code[0]=level select, code[1]=rise/high, code[2]=fall/low
  function automatic bit expect_fire(bit [2:0] code, bit was, bit now_l);
    if (code[0]) return (code[1] && now_l) || (code[2] && !now_l);
    return (code[1] && !was && now_l) || (code[2] && was && !now_l);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(posedge clk); #1;
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    for (int p = 0; p < N; p++) begin
      rd(cfg_at(p), d); check("R1 cfg reset", d, 32'h0);
      rd(val_at(p), d); check("R1 val reset", d, 32'h6);
    end
    rd(STAT, d); check("R1 status reset", d, 32'h0);
    check("R1 irq reset", {31'b0, irq}, 32'h0);
    check("R1 oe reset", {24'b0, pad_oe}, 32'h0);

    // R2 map and stored bits
    wr(cfg_at(3), 32'hFFFF_FFFF);
    rd(cfg_at(3), d); check("R2 cfg mask", d, 32'h8F00_0007);
    wr(cfg_at(3), 32'h0);
    wr(STAT, 32'hFF);
    rd(STAT, d); check("R2 status cleared", d, 32'h0);
    wr(cfg_at(3) + 12'h4, 32'hFFFF_FFFF);
    rd(cfg_at(3) + 12'h4, d); check("R2 hole reads 0", d, 32'h0);
    rd(cfg_at(3), d); check("R2 hole no cfg effect", d, 32'h0);
    rd(val_at(3), d); check("R2 hole no val effect", d, 32'h6);
    wr(12'h084, 32'hFFFF_FFFF);
    rd(12'h084, d); check("R2 beyond pads reads 0", d, 32'h0);
    wr(val_at(5), 32'hFFFF_FFFF);
    rd(val_at(5), d); check("R2 val mask", d, 32'h7);
    check("R2 val oe off", {24'b0, pad_oe}, 32'h0);
    wr(val_at(5), 32'h6);

    // R3 synchronizer latency and input select
    wr(val_at(4), 32'h2);
    rd(val_at(4), d); check("R3 input low", d, 32'h2);
    pad_in[4] = 1'b1;
    tick(1); rd(val_at(4), d); check("R3 after one edge", d, 32'h2);
    tick(1); rd(val_at(4), d); check("R3 after two edges", d, 32'h3);
    wr(val_at(4), 32'h4);
    rd(val_at(4), d); check("R3 stored level when input off", d, 32'h4);
    wr(val_at(4), 32'h5);
    rd(val_at(4), d); check("R3 stored level one", d, 32'h5);
    wr(val_at(4), 32'h6);
    pad_in[4] = 1'b0;
    tick(4);

    // R4 push-pull sweep
    for (int p = 0; p < N; p++) begin
      for (int l = 0; l < 2; l++) begin
        wr(val_at(p), 32'h4 | l);
        check("R4 oe on", {24'b0, pad_oe}, 32'h1 << p);
        check("R4 level", {31'b0, pad_out[p]}, l);
      end
      wr(val_at(p), 32'h6);
      check("R4 oe off", {24'b0, pad_oe}, 32'h0);
    end

    // R5 open drain
    wr(cfg_at(6), 32'h8000_0000);
    wr(val_at(6), 32'h4);
    check("R5 od low oe", {24'b0, pad_oe}, 32'h40);
    check("R5 od low out", {31'b0, pad_out[6]}, 32'h0);
    wr(val_at(6), 32'h5);
    check("R5 od high released", {24'b0, pad_oe}, 32'h0);
    wr(val_at(6), 32'h6);
    wr(cfg_at(6), 32'h0);

    // R6 R7 R8 R11 trigger sweep over every pad and code
    for (int p = 0; p < N; p++) begin
      for (int c = 0; c < 8; c++) begin
        bit ex;
        ex = 0;
        wr(cfg_at(p), 32'(c) << 24);
        tick(5);
        ex |= expect_fire(3'(c), 1'b0, 1'b0);
        rd(STAT, d); check("R6 R7 R8 idle low", d, 32'(ex) << p);
        check("R11 irq idle", {31'b0, irq}, 32'(ex));
        pad_in[p] = 1'b1;
        tick(5);
        ex |= expect_fire(3'(c), 1'b0, 1'b1);
        rd(STAT, d); check("R6 R7 R8 after rise", d, 32'(ex) << p);
        check("R11 irq rise", {31'b0, irq}, 32'(ex));
        pad_in[p] = 1'b0;
        tick(5);
        ex |= expect_fire(3'(c), 1'b1, 1'b0);
        rd(STAT, d); check("R6 R7 R8 after fall", d, 32'(ex) << p);
        wr(cfg_at(p), 32'h0);
        wr(STAT, 32'hFF);
        rd(STAT, d); check("R9 cleared inactive", d, 32'h0);
        check("R11 irq cleared", {31'b0, irq}, 32'h0);
      end
    end

    // R10 level re-set one cycle after clear
    wr(cfg_at(2), 32'h0300_0000);
    pad_in[2] = 1'b1;
    tick(5);
    rd(STAT, d); check("R10 level pending", d, 32'h4);
    wr(STAT, 32'h4);
    rd(STAT, d); check("R10 zero right after clear", d, 32'h0);
    tick(1);
    rd(STAT, d); check("R10 set again next cycle", d, 32'h4);
    wr(cfg_at(2), 32'h0);
    pad_in[2] = 1'b0;
    wr(STAT, 32'hFF);
    tick(4);

    // R9 edge colliding with clear is kept, other bit cleared, zero write ignored
    wr(cfg_at(1), 32'h0200_0000);
    pad_in[1] = 1'b1;
    tick(5);
    rd(STAT, d); check("R9 pad1 pending", d, 32'h2);
    wr(STAT, 32'h0);
    rd(STAT, d); check("R9 zero write ignored", d, 32'h2);
    wr(cfg_at(0), 32'h0200_0000);
    pad_in[0] = 1'b1;
    tick(2);
    wr(STAT, 32'hFF);
    rd(STAT, d); check("R9 edge survives clear", d, 32'h1);
    check("R11 irq held", {31'b0, irq}, 32'h1);

    finish_run();
  end
endmodule